// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog timer on a simple synchronous register bus. It holds three 32-bit registers: a control word, a reload value and the live 16-bit down-count. The input clock feeds an 8-bit programmable prescaler. A fixed divider of 16, 32, 64 or 128 follows it, and together they produce a count tick. Each tick decrements the counter. When the counter expires it reloads from the reload register. Expiry can pulse an interrupt line, start a stretched system reset request, or do both.

Software keeps the system alive by rewriting the count register before it runs out. Clearing the enable bit freezes the count. Clearing the reset-enable bit keeps expiry from ever reaching the reset request.

Top module: `wdt_timer`

## Requirements
- R1: Byte offset 0x00 selects control, 0x04 selects reload and 0x08 selects the live count; reads are combinational. Any other address reads zero, and writes to it change nothing.
- R2: Control fields are: bit 0 reset-enable, bit 2 interrupt-enable, bits 4:3 divide select (0=16, 1=32, 2=64, 3=128), bit 5 enable, bits 15:8 prescale value P. All other control bits read zero.
- R3: After reset, control reads 0x0000801C (prescale 0x80, divide 128, interrupt-enable set, enable and reset-enable clear), and reload and count both read 0x00008000. Both outputs are low.
- R4: When enable goes from 0 to 1, the prescaler and divider restart from zero. With count N the first expiry comes N*(P+1)*D clock edges after the enabling write, where D is the selected divide.
- R5: On expiry the counter reloads from the reload register (value R), so later expiries follow every R*(P+1)*D edges.
- R6: A write to the count register loads the counter at once and does not disturb the prescaler or divider phase. This write is the keep-alive.
- R7: If a count write and an expiring tick fall in the same cycle, the write wins and no expiry happens.
- R8: The interrupt output pulses high for exactly one cycle per expiry, and only if interrupt-enable was set at expiry.
- R9: The reset request goes high on expiry only if reset-enable was set at expiry. It then stays high for at least 128 cycles, and for exactly 128 cycles when it is not retriggered.
- R10: While enable is clear the count holds its value and no expiry occurs.
- R11: A count of 0 expires on the next tick, in the same way as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | One-cycle expiry interrupt |
| rst_req_o | output | 1 | Stretched system reset request |

## Verification
The keep-alive write and the expiring tick can land in the same cycle. The bench provokes this with a count of 1, which makes the tick fall 15 edges after the enabling write, and it issues a count write whose edge consumes that exact tick. The write must win. The bench judges this by the absence of an interrupt or reset at that point, and by an expiry that arrives exactly 32 edges later, counted from the newly loaded value on the unchanged divider phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_COUNT  = 'h8;

  localparam int unsigned PRE_W     = 8;
  localparam int unsigned DIV_SEL_W = 2;

  localparam int unsigned BIT_RST_EN  = 0;
  localparam int unsigned BIT_IRQ_EN  = 2;
  localparam int unsigned LSB_DIV_SEL = 3;
  localparam int unsigned BIT_EN      = 5;
  localparam int unsigned LSB_PRE     = 8;

  typedef struct packed {
    logic [PRE_W-1:0]     pre;
    logic                 en;
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 irq_en;
    logic                 rst_en;
  } wdt_ctrl_t;

  localparam wdt_ctrl_t CTRL_RST = '{pre: 8'h80, en: 1'b0, div_sel: 2'd3,
                                     irq_en: 1'b1, rst_en: 1'b0};
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CNT_RST = 'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_ld_o,
  output logic [CNT_W-1:0]  cnt_ld_val_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);

  wdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= CNT_W'(CNT_RST);
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        ctrl_q.rst_en  <= wdata_i[BIT_RST_EN];
        ctrl_q.irq_en  <= wdata_i[BIT_IRQ_EN];
        ctrl_q.div_sel <= wdata_i[LSB_DIV_SEL +: DIV_SEL_W];
        ctrl_q.en      <= wdata_i[BIT_EN];
        ctrl_q.pre     <= wdata_i[LSB_PRE +: PRE_W];
      end
      if (addr_i == A_RLD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[BIT_RST_EN]               = ctrl_q.rst_en;
        rdata_o[BIT_IRQ_EN]               = ctrl_q.irq_en;
        rdata_o[LSB_DIV_SEL +: DIV_SEL_W] = ctrl_q.div_sel;
        rdata_o[BIT_EN]                   = ctrl_q.en;
        rdata_o[LSB_PRE +: PRE_W]         = ctrl_q.pre;
      end
      A_RLD:   rdata_o[CNT_W-1:0] = reload_q;
      A_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign reload_o     = reload_q;
  assign cnt_ld_o     = wr_en_i && (addr_i == A_CNT);
  assign cnt_ld_val_o = wdata_i[CNT_W-1:0];
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned PRE_W         = 8,
  parameter int unsigned DIV_SEL_W     = 2,
  parameter int unsigned DIV_BASE_LOG2 = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PRE_W-1:0]     pre_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);
  localparam int unsigned DIV_CNT_W = DIV_BASE_LOG2 + (1 << DIV_SEL_W) - 1;

  logic [PRE_W-1:0]     pre_cnt_q;
  logic [DIV_CNT_W-1:0] div_cnt_q;
  logic [DIV_CNT_W:0]   div_lim;
  logic                 pre_last, div_last;

  assign div_lim  = (DIV_CNT_W+1)'((1 << (DIV_BASE_LOG2 + int'(div_sel_i))) - 1);
  // >= keeps the chain sane if the ratio shrinks mid-run
  assign pre_last = pre_cnt_q >= pre_i;
  assign div_last = {1'b0, div_cnt_q} >= div_lim;
  assign tick_o   = en_i && pre_last && div_last;

  // held at zero while disabled: first period after enable is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (!en_i) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_last) begin
      pre_cnt_q <= '0;
      div_cnt_q <= div_last ? '0 : div_cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CNT_RST = 'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // software load beats a coincident expiring tick
  assign expire_o = tick_i && !ld_i && (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(CNT_RST);
    else if (ld_i)     cnt_q <= ld_val_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int unsigned LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned LEN_W = $clog2(LEN + 1);

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (trig_i)        left_q <= LEN_W'(LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_o = left_q != '0;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned CNT_RST       = 'h8000,
  parameter int unsigned DIV_BASE_LOG2 = 4,
  parameter int unsigned RST_LEN       = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload, cnt, cnt_ld_val;
  logic             cnt_ld, tick, expire, irq_q;
  logic             en_w, irq_en_w, rst_en_w;

  assign en_w     = ctrl.en;
  assign irq_en_w = ctrl.irq_en;
  assign rst_en_w = ctrl.rst_en;

  wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_RST(CNT_RST)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .cnt_i(cnt), .rdata_o, .ctrl_o(ctrl), .reload_o(reload),
    .cnt_ld_o(cnt_ld), .cnt_ld_val_o(cnt_ld_val)
  );

  wdt_tick #(
    .PRE_W(PRE_W), .DIV_SEL_W(DIV_SEL_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)
  ) u_tick (
    .clk_i, .rst_ni, .en_i(en_w), .pre_i(ctrl.pre),
    .div_sel_i(ctrl.div_sel), .tick_o(tick)
  );

  wdt_down #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_down (
    .clk_i, .rst_ni, .tick_i(tick), .ld_i(cnt_ld), .ld_val_i(cnt_ld_val),
    .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
  );

  wdt_stretch #(.LEN(RST_LEN)) u_rst (
    .clk_i, .rst_ni, .trig_i(expire && rst_en_w), .pulse_o(rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= expire && irq_en_w;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_LEN = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              en_w,
  input logic              irq_en_w,
  input logic              rst_en_w,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(wdt_pkg::OFS_COUNT);
  localparam int unsigned RUN_W = $clog2(RST_LEN + 1) + 1;

  logic [RUN_W-1:0] run_q;
  logic             cnt_wr;

  assign cnt_wr = wr_en_i && (addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!rst_req_o)         run_q <= '0;
    else if (run_q != '1)        run_q <= run_q + 1'b1;
  end

  a_r8_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r8_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_w));

  a_r9_rst_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(rst_en_w));

  a_r9_rst_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (run_q >= RUN_W'(RST_LEN)));

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (!irq_o && cnt == $past(wdata_i[CNT_W-1:0])));

  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_w && !cnt_wr) |=> $stable(cnt));
endmodule

bind wdt_timer wdt_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .rst_req_o(rst_req_o), .en_w(en_w),
  .irq_en_w(irq_en_w), .rst_en_w(rst_en_w), .cnt(cnt)
);

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8;

  typedef struct packed {
    logic [7:0]  pre;
    logic [1:0]  sel;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic [15:0] first;
    logic [15:0] second;
  } vec_t;

  // first = cnt*(pre+1)*div, second = rld*(pre+1)*div
  localparam vec_t VECS [6] = '{
    '{8'd0, 2'd0, 16'd3, 16'd3, 16'd48,  16'd48},
    '{8'd1, 2'd0, 16'd2, 16'd4, 16'd64,  16'd128},
    '{8'd0, 2'd1, 16'd1, 16'd2, 16'd32,  16'd64},
    '{8'd2, 2'd3, 16'd1, 16'd1, 16'd384, 16'd384},
    '{8'd0, 2'd2, 16'd5, 16'd1, 16'd320, 16'd64},
    '{8'd0, 2'd0, 16'd0, 16'd1, 16'd16,  16'd16}
  };

  wdt_timer dut_i (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // edges until sig (0: irq, 1: rst_req) is seen high at a negedge
  task automatic wait_sig(input bit which, input int max, output int n);
    n = 0;
    forever begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      if ((which ? rst_req_o : irq_o) || n >= max) break;
    end
  endtask

  function automatic logic [31:0] ctrl_w(input bit en, input bit ie, input bit re,
                                         input logic [1:0] sel, input logic [7:0] pre);
    return {16'h0, pre, 2'b00, en, sel, ie, 1'b0, re};
  endfunction

  initial begin
    logic [31:0] rd;
    int n, k;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R3 reset values
    chk("R3 irq", {31'h0, irq_o}, 32'h0);
    chk("R3 rst_req", {31'h0, rst_req_o}, 32'h0);
    bus_rd(A_CTRL, rd); chk("R3 ctrl", rd, 32'h0000_801C);
    bus_rd(A_RLD, rd);  chk("R3 reload", rd, 32'h0000_8000);
    bus_rd(A_CNT, rd);  chk("R3 count", rd, 32'h0000_8000);

    // R2 reserved bits read zero
    bus_wr(A_CTRL, 32'hFFFF_FFDF);
    bus_rd(A_CTRL, rd); chk("R2 ctrl fields", rd, 32'h0000_FF1D);
    bus_wr(A_CTRL, 32'h0);

    // R1 unmapped address
    bus_wr(A_RLD, 32'h1234); bus_wr(A_CNT, 32'h0055);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, rd);   chk("R1 unmapped read", rd, 32'h0);
    bus_rd(A_RLD, rd);  chk("R1 reload kept", rd, 32'h1234);
    bus_rd(A_CNT, rd);  chk("R1 count kept", rd, 32'h0055);
    bus_rd(A_CTRL, rd); chk("R1 ctrl kept", rd, 32'h0);

    // table: R4 first period, R5 reload period, R8 one-cycle, R11 zero count
    foreach (VECS[i]) begin
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_RLD, {16'h0, VECS[i].rld});
      bus_wr(A_CNT, {16'h0, VECS[i].cnt});
      bus_wr(A_CTRL, ctrl_w(1, 1, 0, VECS[i].sel, VECS[i].pre));
      wait_sig(0, 2000, n);
      chk($sformatf("R4 R11 vec%0d first period", i), n, {16'h0, VECS[i].first});
      chk($sformatf("R9 vec%0d no reset", i), {31'h0, rst_req_o}, 32'h0);
      @(posedge clk_i); @(negedge clk_i);
      chk($sformatf("R8 vec%0d pulse width", i), {31'h0, irq_o}, 32'h0);
      wait_sig(0, 2000, k);
      chk($sformatf("R5 vec%0d reload period", i), k + 1, {16'h0, VECS[i].second});
    end

    // R10 freeze while disabled, then R4 restart
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CNT, 32'd10);
    bus_wr(A_CTRL, ctrl_w(1, 1, 0, 2'd0, 8'd0));
    repeat (32) @(posedge clk_i);
    bus_rd(A_CNT, rd); chk("R1 live count", rd, 32'd8);
    bus_wr(A_CTRL, ctrl_w(0, 1, 0, 2'd0, 8'd0));
    k = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk_i); if (irq_o) k++;
    end
    chk("R10 no irq while off", k, 0);
    bus_rd(A_CNT, rd); chk("R10 count held", rd, 32'd8);
    bus_wr(A_CTRL, ctrl_w(1, 1, 0, 2'd0, 8'd0));
    wait_sig(0, 1000, n);
    chk("R4 restart after enable", n, 128);

    // R6 keep-alive: phase kept, expiry 55 edges after write
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_RLD, 32'h100);
    bus_wr(A_CNT, 32'd4);
    bus_wr(A_CTRL, ctrl_w(1, 1, 0, 2'd0, 8'd0));
    repeat (40) @(posedge clk_i);
    bus_wr(A_CNT, 32'd4);
    wait_sig(0, 1000, n);
    chk("R6 keep-alive", n, 55);

    // R7 write on the expiring tick, with R9 reset length
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CNT, 32'd1);
    bus_wr(A_CTRL, ctrl_w(1, 1, 1, 2'd0, 8'd0));
    repeat (15) @(posedge clk_i);
    bus_wr(A_CNT, 32'd2);
    wait_sig(0, 1000, n);
    chk("R7 write wins, expiry later", n, 32);
    chk("R9 reset with irq", {31'h0, rst_req_o}, 32'h1);
    k = 1;
    for (int c = 0; c < 1000; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (rst_req_o) k++; else break;
    end
    chk("R9 reset length", k, 128);

    // R8 irq gated off, reset still fires
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CNT, 32'd1);
    bus_wr(A_CTRL, ctrl_w(1, 0, 1, 2'd0, 8'd0));
    wait_sig(1, 1000, n);
    chk("R9 reset delay", n, 16);
    chk("R8 irq masked", {31'h0, irq_o}, 32'h0);
    bus_wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule